// File: doc/BRIEF.md
# Paged Display RAM Address Generator

This block holds the write position for a byte-organized display memory of 102 columns by 9 pages. Each byte covers eight vertical pixels of one column, and the ninth page is a partial page that carries a single icon row. A command decoder in front of this block sends it three things. It can load the column pointer. It can load the page pointer. It can select the order in which the pointers advance. A separate write strobe marks each data byte that is stored. After every such byte the block moves its position forward by one place.

In horizontal order the column moves first, so a run of bytes fills one page from left to right. In vertical order the page moves first, so consecutive bytes land 102 positions apart in the flat array. Either pointer wraps at its end and carries into the other. The block drives the current column, the current page and a flat byte address (page times column count plus column) to the RAM port. It does not include the RAM array, the panel scan logic or any read path.

Top module: `disp_ram_addr_gen`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, column and page both read 0 and the advance order is horizontal.
- R2: In horizontal order (mode value 0), a write strobe with the column below 101 moves the column up by 1 and leaves the page unchanged.
- R3: In horizontal order, a write strobe at column 101 sets the column to 0 and moves the page up by 1. When the page is 8 at that point, it wraps to 0.
- R4: In vertical order (mode value 1), a write strobe with the page below 8 moves the page up by 1 and leaves the column unchanged.
- R5: In vertical order, a write strobe at page 8 sets the page to 0 and moves the column up by 1. When the column is 101 at that point, it wraps to 0.
- R6: A column load with a value from 0 to 101, or a page load with a value from 0 to 8, sets that pointer to the value on the next cycle.
- R7: A column load above 101, or a page load above 8, is ignored, and the pointer keeps its previous value.
- R8: In any cycle where a column load or a page load is asserted, the write strobe does not advance either pointer.
- R9: The byte address equals page × 102 + column and follows the pointers in the same cycle.
- R10: A mode load captures the mode value (0 = horizontal, 1 = vertical). The new mode governs write strobes from the following cycle onward; a strobe in the same cycle as the mode load still uses the old mode.
- R11: With no strobe and no load, both pointers hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_ld | input | 1 | Capture a new advance order |
| mode_val | input | 1 | Advance order: 0 horizontal, 1 vertical |
| col_ld | input | 1 | Load the column pointer |
| col_val | input | 7 | Column value to load |
| page_ld | input | 1 | Load the page pointer |
| page_val | input | 4 | Page value to load |
| wr_stb | input | 1 | A data byte was written; advance the position |
| col | output | 7 | Current column |
| page | output | 4 | Current page |
| byte_addr | output | 10 | Flat byte address, page × 102 + column |

## Verification
The bench uses the default geometry of 102 columns by 9 pages. These sizes give 7-bit column and 4-bit page load fields, so the bench can drive values beyond the last legal column and page: 102, 127, 9 and 15. With this geometry the bench can also sweep the full 918-byte space in each order. The sweeps reach the corner at column 101, page 8, where both pointers wrap in one step. Because the sweeps cross that corner, the byte address is checked at every value from 0 to 917.

// File: rtl/disp_addr_pkg.sv
package disp_addr_pkg;

  typedef enum logic {
    ORDER_HORIZ = 1'b0,
    ORDER_VERT  = 1'b1
  } adv_order_e;

  // Linear byte index of a (page, column) pair in a page-major array
  function automatic int unsigned lin_index(input int unsigned pg,
                                            input int unsigned cl,
                                            input int unsigned ncols);
    return pg * ncols + cl;
  endfunction

endpackage

// File: rtl/disp_wrap_ctr.sv
module disp_wrap_ctr #(
  parameter int unsigned LIMIT = 102,
  parameter int unsigned W     = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic         step,
  output logic [W-1:0] cnt,
  output logic         at_max
);

  localparam logic [W-1:0] MAXV = W'(LIMIT - 1);

  logic ld_ok;
  logic ld_bad;

  assign ld_ok  = ld && (ld_val <= MAXV);
  assign ld_bad = ld && (ld_val > MAXV);
  assign at_max = (cnt == MAXV);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (ld_ok) begin
      cnt <= ld_val;
    end else if (step && !ld) begin
      cnt <= at_max ? '0 : cnt + 1'b1;
    end
  end

  assert_load_taken_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ld_ok |=> cnt == $past(ld_val));

  assert_bad_load_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ld_bad |=> $stable(cnt));

  assert_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= MAXV);

endmodule

// File: rtl/disp_flat_addr.sv
module disp_flat_addr #(
  parameter int unsigned COLS = 102,
  parameter int unsigned CW   = 7,
  parameter int unsigned PW   = 4,
  parameter int unsigned AW   = 10
) (
  input  logic [PW-1:0] page_i,
  input  logic [CW-1:0] col_i,
  output logic [AW-1:0] addr_o
);
  import disp_addr_pkg::*;

  always_comb begin
    addr_o = AW'(lin_index(int'(page_i), int'(col_i), COLS));
  end

endmodule

// File: rtl/disp_ram_addr_gen.sv
module disp_ram_addr_gen #(
  parameter int unsigned COLS  = 102,
  parameter int unsigned PAGES = 9,
  localparam int unsigned CW   = $clog2(COLS),
  localparam int unsigned PW   = $clog2(PAGES),
  localparam int unsigned AW   = $clog2(COLS * PAGES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_ld,
  input  logic          mode_val,
  input  logic          col_ld,
  input  logic [CW-1:0] col_val,
  input  logic          page_ld,
  input  logic [PW-1:0] page_val,
  input  logic          wr_stb,
  output logic [CW-1:0] col,
  output logic [PW-1:0] page,
  output logic [AW-1:0] byte_addr
);
  import disp_addr_pkg::*;

  adv_order_e order_q;
  logic       wr_adv;
  logic       col_step;
  logic       page_step;
  logic       col_last;
  logic       page_last;
  logic       is_vert;

  always_ff @(posedge clk) begin
    if (!rst_n)       order_q <= ORDER_HORIZ;
    else if (mode_ld) order_q <= adv_order_e'(mode_val);
  end

  assign is_vert   = (order_q == ORDER_VERT);
  assign wr_adv    = wr_stb && !col_ld && !page_ld;
  assign col_step  = wr_adv && (!is_vert || page_last);
  assign page_step = wr_adv && ( is_vert || col_last);

  disp_wrap_ctr #(.LIMIT(COLS), .W(CW)) u_col_ctr (
    .clk   (clk),
    .rst_n (rst_n),
    .ld    (col_ld),
    .ld_val(col_val),
    .step  (col_step),
    .cnt   (col),
    .at_max(col_last)
  );

  disp_wrap_ctr #(.LIMIT(PAGES), .W(PW)) u_page_ctr (
    .clk   (clk),
    .rst_n (rst_n),
    .ld    (page_ld),
    .ld_val(page_val),
    .step  (page_step),
    .cnt   (page),
    .at_max(page_last)
  );

  disp_flat_addr #(.COLS(COLS), .CW(CW), .PW(PW), .AW(AW)) u_flat (
    .page_i(page),
    .col_i (col),
    .addr_o(byte_addr)
  );

  assert_reset_horiz_R1: assert property (@(posedge clk)
    !rst_n |=> (col == '0) && (page == '0) && (order_q == ORDER_HORIZ));

  assert_horiz_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_adv && !is_vert && !col_last) |=> (col == $past(col) + 1'b1) && $stable(page));

  assert_horiz_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_adv && !is_vert && col_last) |=> (col == '0) && (page != $past(page)));

  assert_vert_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_adv && is_vert && !page_last) |=> (page == $past(page) + 1'b1) && $stable(col));

  assert_vert_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_adv && is_vert && page_last) |=> (page == '0) && (col != $past(col)));

  assert_load_priority_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (col_ld && !page_ld) |=> $stable(page));

  assert_addr_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    byte_addr < AW'(COLS * PAGES));

  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_stb && !col_ld && !page_ld) |=> $stable(col) && $stable(page));

endmodule

// File: tb/disp_ram_addr_gen_tb.sv
module disp_ram_addr_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NCOL = 102;
  localparam int NPAGE = 9;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_ld = 1'b0, mode_val = 1'b0;
  logic       col_ld = 1'b0, page_ld = 1'b0, wr_stb = 1'b0;
  logic [6:0] col_val = '0;
  logic [3:0] page_val = '0;
  logic [6:0] col;
  logic [3:0] page;
  logic [9:0] byte_addr;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int m_col = 0, m_page = 0, m_vert = 0;
  string phase = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  disp_ram_addr_gen u_dut (
    .clk(clk), .rst_n(rst_n), .mode_ld(mode_ld), .mode_val(mode_val),
    .col_ld(col_ld), .col_val(col_val), .page_ld(page_ld), .page_val(page_val),
    .wr_stb(wr_stb), .col(col), .page(page), .byte_addr(byte_addr)
  );

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    check({phase, " column"}, int'(col), m_col);
    check({phase, " page"}, int'(page), m_page);
    check("R9 byte address", int'(byte_addr), m_page * NCOL + m_col);
  endtask

  // Apply one cycle of stimulus, advance the model, compare after the edge
  task automatic cyc(bit w, bit cl, int cv, bit pl, int pv, bit ml, bit mv);
    wr_stb = w; col_ld = cl; col_val = 7'(cv);
    page_ld = pl; page_val = 4'(pv); mode_ld = ml; mode_val = mv;
    @(posedge clk);
    if (cl || pl) begin
      if (cl && cv < NCOL) m_col = cv;
      if (pl && pv < NPAGE) m_page = pv;
    end else if (w) begin
      if (m_vert == 0) begin
        m_col++;
        if (m_col == NCOL) begin m_col = 0; m_page = (m_page + 1) % NPAGE; end
      end else begin
        m_page++;
        if (m_page == NPAGE) begin m_page = 0; m_col = (m_col + 1) % NCOL; end
      end
    end
    if (ml) m_vert = mv;
    #1;
    compare_all();
    @(negedge clk);
    wr_stb = 0; col_ld = 0; page_ld = 0; mode_ld = 0;
  endtask

  task automatic wr(int n);
    for (int i = 0; i < n; i++) cyc(1, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic goto_pos(int c, int p);
    cyc(0, 1, c, 1, p, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    phase = "R1";
    compare_all();
    rst_n = 1'b1;
    @(posedge clk); #1;
    compare_all();
    @(negedge clk);

    phase = "R2"; wr(5);
    phase = "R11"; cyc(0, 0, 0, 0, 0, 0, 0); cyc(0, 0, 0, 0, 0, 0, 0);
    phase = "R6"; cyc(0, 1, 99, 0, 0, 0, 0); cyc(0, 0, 0, 1, 7, 0, 0);
    phase = "R3"; wr(5);
    goto_pos(100, 8); wr(3);
    phase = "R7";
    cyc(0, 1, 102, 0, 0, 0, 0); cyc(0, 1, 127, 0, 0, 0, 0);
    cyc(0, 0, 0, 1, 9, 0, 0);   cyc(0, 0, 0, 1, 15, 0, 0);
    cyc(0, 1, 120, 1, 12, 0, 0);
    phase = "R8";
    cyc(1, 1, 40, 0, 0, 0, 0); cyc(1, 0, 0, 1, 3, 0, 0);
    cyc(1, 1, 110, 0, 0, 0, 0);
    phase = "R10"; cyc(1, 0, 0, 0, 0, 1, 1);
    phase = "R4"; goto_pos(10, 0); wr(6);
    phase = "R5"; wr(6); goto_pos(101, 8); wr(2);
    phase = "R10"; cyc(1, 0, 0, 0, 0, 1, 0); wr(2);
    phase = "R3"; goto_pos(0, 0); wr(NCOL * NPAGE + 5);
    phase = "R10"; cyc(0, 0, 0, 0, 0, 1, 1);
    phase = "R5"; goto_pos(0, 0); wr(NCOL * NPAGE + 5);
    phase = "R1"; rst_n = 1'b0; mode_val = 1'b1;
    @(posedge clk); m_col = 0; m_page = 0; m_vert = 0; #1;
    compare_all();
    @(negedge clk); rst_n = 1'b1;
    phase = "R1"; wr(3);

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule